// File: doc/BRIEF.md
# Single-Bank GPIO Port with Masked Half-Word Writes

This block is one bank of general-purpose pins, up to 32 of them, sitting on a plain register bus. The bus has a byte address, a write strobe, 32-bit write data and combinational read data. The bank keeps three registers: output values, pin direction and output enable. It drives a pad output vector and a pad enable vector, and it samples a pad input vector.

Software can load the output values in three ways. It can write the whole output register. It can also use one of two write-only half-word ports, one for the lower sixteen pins and one for the upper sixteen. A half-word write carries a 16-bit mask in its upper half and 16 data bits in its lower half, so a single pin can be changed without first reading the register back.

A separate read-only location returns the pin levels after a two-flop synchronizer. A pad is driven only when both its direction bit and its enable bit are set. The parameter `PIN_COUNT` trims the bank to narrower widths, for example 22 or 26 pins; storage bits above that count do not exist.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset, the output, direction and enable registers read 0, so every pin is an undriven input.
- R2: A write to address 0x000 updates output bit i (i in 0..15) with write-data bit i only where write-data bit 16+i is 0. Where bit 16+i is 1, output bit i keeps its value. Bits 16..31 are not touched.
- R3: A write to address 0x004 updates output bit 16+i with write-data bit i only where write-data bit 16+i is 0. Output bits 0..15 are not touched.
- R4: Address 0x040 holds the full output register; it is readable and writable, and its bit n drives pad_out[n].
- R5: A read of address 0x060 returns pad_in as it was two clock edges earlier. Writes to 0x060 change no state.
- R6: Address 0x204 (direction, 1 = output) and address 0x208 (output enable) are readable and writable. pad_oe[n] is 1 only when both bit n of direction and bit n of enable are 1.
- R7: Reads of 0x000, 0x004 and of any unmapped address return 0.
- R8: Register bits at or above PIN_COUNT read as 0 and ignore writes, whichever port writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | PIN_COUNT | Pin levels from the pads |
| pad_out | output | PIN_COUNT | Values driven to the pads |
| pad_oe | output | PIN_COUNT | Per-pin drive enable |

## Verification
The masked ports are tried with four kinds of mask. An all-zero mask shows that the port can replace all sixteen bits at once. An all-one mask shows that nothing moves. A mask with a single zero bit shows that exactly that one pin is updated, in both halves. A high-half write that targets pins above a 22-pin bank shows that those bits are trimmed. Full-register writes of all ones and of zero separate the trimmed bits from the real ones. Direction and enable are given overlapping but different patterns, so that the enable output can be told apart from either register alone. A pin pattern applied to the inputs, followed by a read one edge later and another read two edges later, separates the synchronizer delay from a direct path.

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);

  localparam logic [32:0] TOP_BIT  = 33'd1 << PIN_COUNT;
  localparam logic [31:0] PIN_MASK = 32'(TOP_BIT - 33'd1);

  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(12'h060);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(12'h204);
  localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(12'h208);

  logic [31:0] data_q, dir_q, oen_q, sync1_q, sync2_q;
  logic [15:0] wmask, wval;
  logic [31:0] lo_next, hi_next;

  assign wmask = bus_wdata[31:16];
  assign wval  = bus_wdata[15:0];

  assign lo_next = {data_q[31:16], (data_q[15:0] & wmask) | (wval & ~wmask)};
  assign hi_next = {(data_q[31:16] & wmask) | (wval & ~wmask), data_q[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_LO:    data_q <= lo_next & PIN_MASK;
        A_HI:    data_q <= hi_next & PIN_MASK;
        A_DATA:  data_q <= bus_wdata & PIN_MASK;
        A_DIR:   dir_q  <= bus_wdata & PIN_MASK;
        A_OEN:   oen_q  <= bus_wdata & PIN_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= 32'(pad_in);
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_LIVE:  bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_OEN:   bus_rdata = oen_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = data_q[PIN_COUNT-1:0];
  assign pad_oe  = dir_q[PIN_COUNT-1:0] & oen_q[PIN_COUNT-1:0];

endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [PIN_COUNT-1:0] pad_in,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe
);
  localparam logic [32:0] TOP_BIT  = 33'd1 << PIN_COUNT;
  localparam logic [31:0] PIN_MASK = 32'(TOP_BIT - 33'd1);

  logic [31:0] out32;
  logic [1:0]  age;
  assign out32 = 32'(pad_out);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;

  p_lo_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h000)) |=>
      (((out32 ^ $past(out32)) & {16'hFFFF, $past(bus_wdata[31:16])}) == 32'd0));

  p_hi_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h004)) |=>
      (((out32 ^ $past(out32)) & {$past(bus_wdata[31:16]), 16'hFFFF}) == 32'd0));

  p_full_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h040)) |=>
      (out32 == ($past(bus_wdata) & PIN_MASK)));

  p_live_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && bus_addr == ADDR_W'(12'h060)) |->
      (bus_rdata == 32'($past(pad_in, 2))));

  p_ro_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12'h060)) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_oe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe) |->
      $past(bus_we && (bus_addr == ADDR_W'(12'h204) || bus_addr == ADDR_W'(12'h208))));

  p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(12'h000) || bus_addr == ADDR_W'(12'h004)) |-> (bus_rdata == 32'd0));

  p_dead_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~PIN_MASK) == 32'd0));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_port_tb.sv
module gpio_bank_port_tb;
  localparam int PINS = 22;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_port #(.PIN_COUNT(PINS), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // behavioural reference
  bit [31:0] m_data, m_dir, m_oen;
  bit [31:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_oen = 0; hist.delete();
    end else begin
      if (bus_we) begin
        if (bus_addr == 12'h000) begin
          for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_data[i] = bus_wdata[i];
        end else if (bus_addr == 12'h004) begin
          for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_data[16+i] = bus_wdata[i];
        end else if (bus_addr == 12'h040) m_data = bus_wdata;
        else if (bus_addr == 12'h204) m_dir = bus_wdata;
        else if (bus_addr == 12'h208) m_oen = bus_wdata;
        for (int i = PINS; i < 32; i++) begin
          m_data[i] = 0; m_dir[i] = 0; m_oen[i] = 0;
        end
      end
      hist.push_back(32'(pad_in));
      if (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input [31:0] got, input [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // per-cycle comparison of the pad outputs against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 pad_out vs model", 32'(pad_out), m_data);
    chk("R6 pad_oe vs model", 32'(pad_oe), m_dir & m_oen);
  end

  task automatic wr(input [11:0] a, input [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input [11:0] a, input [31:0] exp, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h040, 32'h0, "R1 data after reset");
    rd(12'h204, 32'h0, "R1 dir after reset");
    rd(12'h208, 32'h0, "R1 oen after reset");
    chk("R1 pad_oe after reset", 32'(pad_oe), 32'h0);

    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h003F_FFFF, "R8 full write trimmed");
    chk("R4 pad_out all ones", 32'(pad_out), 32'h003F_FFFF);
    wr(12'h040, 32'h0);
    rd(12'h040, 32'h0, "R4 full write zero");

    wr(12'h000, 32'h0000_A5C3);
    rd(12'h040, 32'h0000_A5C3, "R2 open mask");
    wr(12'h000, 32'hFFFF_0000);
    rd(12'h040, 32'h0000_A5C3, "R2 closed mask");
    wr(12'h000, 32'hFFFE_0000);
    rd(12'h040, 32'h0000_A5C2, "R2 single bit clear");
    wr(12'h000, 32'hFFEF_0010);
    rd(12'h040, 32'h0000_A5D2, "R2 single bit set");

    wr(12'h004, 32'hFFFE_0001);
    rd(12'h040, 32'h0001_A5D2, "R3 pin16 set");
    wr(12'h004, 32'h0000_FFFF);
    rd(12'h040, 32'h003F_A5D2, "R3 R8 high open mask trimmed");
    wr(12'h004, 32'hFFDF_0000);
    rd(12'h040, 32'h001F_A5D2, "R3 pin21 clear");

    rd(12'h000, 32'h0, "R7 low port reads zero");
    rd(12'h004, 32'h0, "R7 high port reads zero");
    rd(12'h100, 32'h0, "R7 unmapped reads zero");

    wr(12'h204, 32'h00FF_00FF);
    rd(12'h204, 32'h003F_00FF, "R6 R8 dir readback");
    wr(12'h208, 32'h0000_0F0F);
    rd(12'h208, 32'h0000_0F0F, "R6 oen readback");
    chk("R6 pad_oe overlap", 32'(pad_oe), 32'h0000_000F);

    @(negedge clk);
    pad_in = 22'h15A5A5;
    rd(12'h060, 32'h0, "R5 one edge: old value");
    rd(12'h060, 32'h0015_A5A5, "R5 two edges: new value");
    wr(12'h060, 32'hFFFF_FFFF);
    rd(12'h060, 32'h0015_A5A5, "R5 live unchanged by write");
    rd(12'h040, 32'h001F_A5D2, "R5 write to live ignored");
    rd(12'h204, 32'h003F_00FF, "R5 dir untouched by live write");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule